// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in memory. A requester presents a virtual address and an access kind: read, write or execute. The walker fetches a directory entry, then a leaf entry, over a single word-read memory port, and answers with one response pulse. That response carries the physical address and the leaf's permission flags, or a fault code. Pages are 4 KB, so the low twelve address bits are never translated.

Only one walk is in flight at a time. A new request is taken only while the walker is idle. The base of the directory is given as a physical page number, and it is captured when a request is accepted. The walker only reads entries. It never writes one back, so it keeps no dirty-bit or usage-bit state.

Top module: `ptw_top`

## Requirements
- R1: On a successful walk, rsp_paddr equals the leaf entry's page number in bits 31:12, and bits 11:0 equal the request's virtual bits 11:0.
- R2: The first read goes to address {base page number, vaddr[31:22], 2'b00}. The second read goes to {directory entry page number, vaddr[21:12], 2'b00}. The base page number is the value on ptbr_ppn when the request is accepted.
- R3: Entry layout: bit 31 valid, bit 30 read, bit 29 write, bit 28 execute, bit 27 dirty, bits 26:20 reserved, bits 19:0 page number. An entry is usable only when its valid bit is set and its reserved bits are zero.
- R4: An unusable directory entry ends the walk with rsp_fault = 1 (page fault). Exactly one memory read is issued, rsp_paddr is 0 and rsp_perm is 0.
- R5: An unusable leaf entry gives rsp_fault = 1 after exactly two memory reads, with rsp_paddr 0 and rsp_perm 0.
- R6: Access codes are 0 read, 1 write and 2 execute. Each needs the leaf's read, write or execute bit respectively. Code 3 is never allowed. A usable leaf that does not allow the access gives rsp_fault = 2 (protection fault) with rsp_paddr 0.
- R7: rsp_perm is {read, write, execute, dirty} of a usable leaf, as bits 3 to 0. Fault code 0 means the translation succeeded.
- R8: req_ready is high only while idle. Request inputs presented during a walk are ignored.
- R9: Each accepted request yields exactly one rsp_valid pulse, one cycle long.
- R10: A memory read request holds its address until mem_rd_ready is sampled high. At most one read is outstanding, and read data is taken only after the address has been handed over.
- R11: After reset, req_ready is 1, while rsp_valid and mem_rd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptbr_ppn | input | 20 | Physical page number of the first-level directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_perm | output | 4 | Leaf flags {read, write, execute, dirty} |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| mem_rd_valid | output | 1 | Memory word read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word read from memory |

## Verification
The bench targets an invalid directory entry. A walker that ignored it would issue a second read from a garbage table and report a wrong address or a wrong fault. It also targets a leaf that is valid but lacks the needed permission, the never-allowed access code 3, and an entry with reserved bits set. Each must fault with the right code rather than translate. Other cases are a changed base page number, which a walker using a stale or misplaced base would translate to the old page, and extreme offsets and indices at 0xFFF and 0x3FF, which expose slicing errors. A stalled memory ready with long read latency, and request inputs held high in the middle of a walk, catch a walker that drops its address, takes data early, or starts a second walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 10;
    localparam int PPN_W    = 20;
    localparam int ENT_W    = 32;
    localparam int ENT_SH   = 2;
    localparam int PA_W     = PPN_W + OFF_W;
    localparam int FLAG_W   = 5;
    localparam int RSVD_W   = ENT_W - FLAG_W - PPN_W;
    localparam int PERM_W   = 4;

    typedef struct packed {
        logic              v;
        logic              r;
        logic              w;
        logic              x;
        logic              d;
        logic [RSVD_W-1:0] rsvd;
        logic [PPN_W-1:0]  ppn;
    } pte_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_READ_PTE,
        ST_DONE
    } walk_st_e;

    function automatic logic entry_usable(pte_t e);
        return e.v && (e.rsvd == '0);
    endfunction

    function automatic logic access_allowed(acc_e a, pte_t e);
        logic ok;
        case (a)
            ACC_READ:  ok = e.r;
            ACC_WRITE: ok = e.w;
            ACC_EXEC:  ok = e.x;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic             leaf,
    input  logic [PPN_W-1:0] dir_ppn,
    input  logic [PPN_W-1:0] tbl_ppn,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PA_W-1:0]  addr
);
    localparam int IDX_HI_LSB = OFF_W + IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    assign dir_idx = vaddr[IDX_HI_LSB +: IDX_W];
    assign tbl_idx = vaddr[OFF_W +: IDX_W];

    always_comb begin
        if (leaf)
            addr = {tbl_ppn, tbl_idx, {ENT_SH{1'b0}}};
        else
            addr = {dir_ppn, dir_idx, {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0]  word,
    input  logic              leaf,
    input  acc_e              access,
    input  logic [OFF_W-1:0]  offset,
    output fault_e            fault,
    output logic [PA_W-1:0]   paddr,
    output logic [PERM_W-1:0] perm,
    output logic [PPN_W-1:0]  next_ppn
);
    pte_t ent;
    assign ent      = pte_t'(word);
    assign next_ppn = ent.ppn;

    always_comb begin
        fault = FLT_NONE;
        paddr = '0;
        perm  = '0;
        if (!entry_usable(ent)) begin
            fault = FLT_PAGE;
        end else if (leaf) begin
            perm = {ent.r, ent.w, ent.x, ent.d};
            if (!access_allowed(access, ent))
                fault = FLT_PROT;
            else
                paddr = {ent.ppn, offset};
        end
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PPN_W-1:0]  ptbr_ppn,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  acc_e              req_access,
    output logic              req_ready,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    input  logic              mem_rsp_valid,
    input  fault_e            ev_fault,
    input  logic [PA_W-1:0]   ev_paddr,
    input  logic [PERM_W-1:0] ev_perm,
    input  logic [PPN_W-1:0]  ev_next_ppn,
    output walk_st_e          state,
    output logic [VA_W-1:0]   vaddr_q,
    output acc_e              access_q,
    output logic [PPN_W-1:0]  dir_ppn_q,
    output logic [PPN_W-1:0]  tbl_ppn_q,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm,
    output fault_e            rsp_fault
);
    logic sent_q;
    logic reading;
    logic data_in;

    assign reading      = (state == ST_READ_DIR) || (state == ST_READ_PTE);
    assign req_ready    = (state == ST_IDLE);
    assign mem_rd_valid = reading && !sent_q;
    assign data_in      = reading && sent_q && mem_rsp_valid;
    assign rsp_valid    = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sent_q    <= 1'b0;
            vaddr_q   <= '0;
            access_q  <= ACC_READ;
            dir_ppn_q <= '0;
            tbl_ppn_q <= '0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q   <= req_vaddr;
                        access_q  <= req_access;
                        dir_ppn_q <= ptbr_ppn;
                        sent_q    <= 1'b0;
                        state     <= ST_READ_DIR;
                    end
                end
                ST_READ_DIR, ST_READ_PTE: begin
                    if (mem_rd_valid && mem_rd_ready)
                        sent_q <= 1'b1;
                    if (data_in) begin
                        sent_q <= 1'b0;
                        if (state == ST_READ_PTE || ev_fault != FLT_NONE) begin
                            rsp_paddr <= ev_paddr;
                            rsp_perm  <= ev_perm;
                            rsp_fault <= ev_fault;
                            state     <= ST_DONE;
                        end else begin
                            tbl_ppn_q <= ev_next_ppn;
                            state     <= ST_READ_PTE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [19:0] ptbr_ppn,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_access,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic [3:0]  rsp_perm,
    output logic [1:0]  rsp_fault,
    output logic        mem_rd_valid,
    input  logic        mem_rd_ready,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    walk_st_e          state;
    logic [VA_W-1:0]   vaddr_q;
    acc_e              access_q;
    logic [PPN_W-1:0]  dir_ppn_q;
    logic [PPN_W-1:0]  tbl_ppn_q;
    fault_e            ev_fault;
    logic [PA_W-1:0]   ev_paddr;
    logic [PERM_W-1:0] ev_perm;
    logic [PPN_W-1:0]  ev_next_ppn;
    fault_e            fault_q;
    logic              leaf;

    assign leaf      = (state == ST_READ_PTE);
    assign rsp_fault = fault_q;

    ptw_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ptbr_ppn     (ptbr_ppn),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_access   (acc_e'(req_access)),
        .req_ready    (req_ready),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .ev_fault     (ev_fault),
        .ev_paddr     (ev_paddr),
        .ev_perm      (ev_perm),
        .ev_next_ppn  (ev_next_ppn),
        .state        (state),
        .vaddr_q      (vaddr_q),
        .access_q     (access_q),
        .dir_ppn_q    (dir_ppn_q),
        .tbl_ppn_q    (tbl_ppn_q),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_perm     (rsp_perm),
        .rsp_fault    (fault_q)
    );

    ptw_addr_gen u_addr (
        .leaf   (leaf),
        .dir_ppn(dir_ppn_q),
        .tbl_ppn(tbl_ppn_q),
        .vaddr  (vaddr_q),
        .addr   (mem_rd_addr)
    );

    ptw_entry_eval u_eval (
        .word    (mem_rsp_data),
        .leaf    (leaf),
        .access  (access_q),
        .offset  (vaddr_q[OFF_W-1:0]),
        .fault   (ev_fault),
        .paddr   (ev_paddr),
        .perm    (ev_perm),
        .next_ppn(ev_next_ppn)
    );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [11:0] req_off,
    input logic        rsp_valid,
    input logic [1:0]  rsp_fault,
    input logic [31:0] rsp_paddr,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rsp_valid
);
    logic [11:0] off_q;
    logic        outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q       <= '0;
            outstanding <= 1'b0;
        end else begin
            if (req_valid && req_ready)
                off_q <= req_off;
            if (mem_rd_valid && mem_rd_ready)
                outstanding <= 1'b1;
            else if (mem_rsp_valid)
                outstanding <= 1'b0;
        end
    end

    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r10_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !outstanding);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_not_ready_at_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[11:0] == off_q));

    a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0));

    a_r7_fault_code_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault != 2'd3));

    a_r11_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (req_ready && !rsp_valid && !mem_rd_valid));
endmodule

bind ptw_top ptw_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_off      (req_vaddr[11:0]),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_paddr    (rsp_paddr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/ptw_top_bench.sv
`timescale 1ns/1ps
module ptw_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] ptbr_ppn = 20'h00080;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_perm;
    logic [1:0]  rsp_fault;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    ptw_top u_ptw_top (.*);

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  flt;
        logic [3:0]  perm;
        int          reads;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [31:0] mem [logic [31:0]];
    int rd_count = 0;
    int cyc = 0;
    bit stall_mode = 0;
    int lat = 0;
    bit pend = 0;
    int pend_cnt = 0;
    logic [31:0] pend_addr = '0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mkpte(bit v, bit r, bit w, bit x, bit d, logic [19:0] ppn);
        return {v, r, w, x, d, 7'b0, ppn};
    endfunction

    function automatic logic [31:0] mkva(logic [9:0] di, logic [9:0] ti, logic [11:0] off);
        return {di, ti, off};
    endfunction

    function automatic bit usable(logic [31:0] e);
        return e[31] && (e[26:20] == 7'd0);
    endfunction

    function automatic exp_t model(logic [31:0] va, logic [1:0] acc, string tag);
        exp_t e;
        logic [31:0] de, pe;
        bit ok;
        e.tag = tag; e.pa = 0; e.perm = 0; e.flt = 0;
        de = rd({ptbr_ppn, va[31:22], 2'b00});
        if (!usable(de)) begin
            e.flt = 1; e.reads = 1; return e;
        end
        pe = rd({de[19:0], va[21:12], 2'b00});
        e.reads = 2;
        if (!usable(pe)) begin
            e.flt = 1; return e;
        end
        e.perm = pe[30:27];
        case (acc)
            2'd0: ok = pe[30];
            2'd1: ok = pe[29];
            2'd2: ok = pe[28];
            default: ok = 0;
        endcase
        if (ok) e.pa = {pe[19:0], va[11:0]};
        else e.flt = 2;
        return e;
    endfunction

    // memory responder
    always @(negedge clk) begin
        cyc++;
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = rd(pend_addr);
                pend = 0;
            end else pend_cnt--;
        end
        mem_rd_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
        if (!rst && mem_rd_valid && mem_rd_ready) begin
            pend = 1; pend_cnt = lat; pend_addr = mem_rd_addr; rd_count++;
        end
    end

    // monitor
    bit was_rsp = 0;
    always @(negedge clk) begin
        if (was_rsp) check("R9 pulse low next cycle", {31'b0, rsp_valid}, 32'd0);
        was_rsp = 0;
        if (!rst && rsp_valid) begin
            was_rsp = 1;
            if (q.size() == 0) begin
                check("R9 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " paddr"}, rsp_paddr, e.pa);
                check({e.tag, " fault"}, {30'b0, rsp_fault}, {30'b0, e.flt});
                check({e.tag, " perm"}, {28'b0, rsp_perm}, {28'b0, e.perm});
                check({e.tag, " reads"}, rd_count, e.reads);
            end
        end
    end

    task automatic send(logic [31:0] va, logic [1:0] acc, string tag, bit busy_poke = 0);
        q.push_back(model(va, acc, tag));
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_count = 0;
        req_valid = 1; req_vaddr = va; req_access = acc;
        @(negedge clk);
        if (busy_poke) begin
            req_vaddr = mkva(10'd2, 10'd0, 12'h0); req_access = 2'd3;
            for (int i = 0; i < 2; i++) begin
                check("R8 req_ready low while busy", {31'b0, req_ready}, 32'd0);
                @(negedge clk);
            end
        end
        req_valid = 0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // tables under base page 0x00080
        mem[{20'h00080, 10'd1, 2'b00}]     = mkpte(1,0,0,0,0, 20'h00100);
        mem[{20'h00080, 10'h3FF, 2'b00}]   = mkpte(1,0,0,0,0, 20'h00200);
        mem[{20'h00080, 10'd4, 2'b00}]     = mkpte(1,1,1,1,0, 20'h00100) | 32'h0010_0000;
        mem[{20'h00100, 10'd2, 2'b00}]     = mkpte(1,1,1,0,1, 20'h4123B);
        mem[{20'h00100, 10'd3, 2'b00}]     = mkpte(1,1,0,0,0, 20'hC20A3);
        mem[{20'h00100, 10'd4, 2'b00}]     = mkpte(1,1,0,1,0, 20'h10044);
        mem[{20'h00100, 10'd6, 2'b00}]     = mkpte(1,1,1,1,1, 20'h55555) | 32'h0400_0000;
        mem[{20'h00100, 10'h3FF, 2'b00}]   = mkpte(1,1,1,1,0, 20'hFFFFF);
        mem[{20'h00200, 10'h3FF, 2'b00}]   = mkpte(1,1,1,1,0, 20'hABCDE);
        // tables under base page 0x12345
        mem[{20'h12345, 10'd1, 2'b00}]     = mkpte(1,0,0,0,0, 20'h00300);
        mem[{20'h00300, 10'd2, 2'b00}]     = mkpte(1,1,0,0,0, 20'h77777);

        repeat (4) @(negedge clk);
        check("R11 req_ready in reset", {31'b0, req_ready}, 32'd1);
        check("R11 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        rst = 0;
        @(negedge clk);
        check("R11 req_ready after reset", {31'b0, req_ready}, 32'd1);
        check("R11 mem_rd_valid after reset", {31'b0, mem_rd_valid}, 32'd0);

        send(mkva(10'd1, 10'd2, 12'hABC), 2'd0, "R1 R7 read ok");
        send(mkva(10'd1, 10'd2, 12'h000), 2'd1, "R1 R6 write ok");
        send(mkva(10'd1, 10'd3, 12'h123), 2'd1, "R6 write to read-only");
        send(mkva(10'd1, 10'd3, 12'h123), 2'd2, "R6 exec without x");
        send(mkva(10'd1, 10'd3, 12'hFFF), 2'd0, "R1 read offset fff");
        send(mkva(10'd1, 10'd4, 12'h010), 2'd2, "R6 exec ok");
        send(mkva(10'd1, 10'd4, 12'h010), 2'd1, "R6 write to code page");
        send(mkva(10'd1, 10'd5, 12'h444), 2'd0, "R5 leaf invalid");
        send(mkva(10'd1, 10'd6, 12'h444), 2'd0, "R3 R5 leaf reserved set");
        send(mkva(10'd2, 10'd0, 12'h444), 2'd0, "R4 dir invalid");
        send(mkva(10'd4, 10'd2, 12'h444), 2'd0, "R3 R4 dir reserved set");
        send(mkva(10'd1, 10'h3FF, 12'h001), 2'd3, "R6 access code 3");
        send(mkva(10'h3FF, 10'h3FF, 12'hFFF), 2'd2, "R2 max indices");

        stall_mode = 1; lat = 3;
        send(mkva(10'd1, 10'd2, 12'h5A5), 2'd1, "R10 stalled write ok");
        send(mkva(10'd2, 10'd9, 12'h001), 2'd0, "R10 R4 stalled dir fault");
        send(mkva(10'd1, 10'd3, 12'h777), 2'd0, "R8 busy inputs ignored", 1);
        stall_mode = 0; lat = 0;
        send(mkva(10'd1, 10'd4, 12'h222), 2'd0, "R8 read after busy test");

        ptbr_ppn = 20'h12345;
        send(mkva(10'd1, 10'd2, 12'hABC), 2'd0, "R2 new base");
        send(mkva(10'd1, 10'd2, 12'hABC), 2'd1, "R2 new base write prot");
        ptbr_ppn = 20'h00080;
        send(mkva(10'd1, 10'd2, 12'hABC), 2'd0, "R2 old base again");

        repeat (3) @(negedge clk);
        check("R9 no stray responses", q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule